// File: doc/BRIEF.md
# CPU Reset and Boot Configuration Sequencer

This block brings a CPU out of power-up in a fixed, timed order. From a single power-on reset it derives two active-low reset outputs: a cold reset, followed later by a warm reset. While the sequence runs, the CPU's bus-grant pin and its four interrupt pins do not carry grants or interrupts. They carry a static boot pattern that the CPU samples to learn its boot PROM width and whether its internal timer is enabled.

A short settle window follows the release of warm reset. After it, the block switches the same pins to normal duty. Interrupt line 0 then follows the infrared interface's interrupt, and line 1 follows the audio DAC's interrupt, each through a two-stage synchronizer. The spare lines and bus grant are parked inactive. A done flag marks the switch-over and stays set until the next power-on reset. Everything is timed from the system clock. All phase lengths and both boot settings are parameters.

Top module: `boot_reset_seq`

## Requirements
- R1: While `rst` is high, and on the first clock edge at which it is sampled high, the block forces `cpu_cold_rst_n`=0, `cpu_warm_rst_n`=0 and `boot_done`=0, and drives the boot pattern onto the pins.
- R2: `cpu_cold_rst_n` goes high right after the 64th rising edge at which `rst` is sampled low, counted from the release of `rst`. It stays low before that edge.
- R3: `cpu_warm_rst_n` goes high 32 edges after cold reset releases, which is right after edge 96 from the release of `rst`.
- R4: The boot pattern holds until 4 edges after warm reset releases, which is through edge 99. In the pattern `cpu_gnt_n`=0 and `cpu_irq_n[3]`=1. Bits `cpu_irq_n[1:0]` carry the PROM width code: 8-bit is 00, 16-bit is 01 (the default), 32-bit is 10.
- R5: `cpu_irq_n[2]` in the pattern equals the timer-enable parameter, which defaults to 1. The default pattern is therefore `cpu_irq_n`=4'b1101 with `cpu_gnt_n`=0.
- R6: In normal mode, which begins right after edge 100, `cpu_irq_n[3:2]`=2'b11 and `cpu_gnt_n`=1.
- R7: In normal mode, `cpu_irq_n[0]` is `ir_irq_n` and `cpu_irq_n[1]` is `dac_irq_n`, each as it was sampled two rising edges earlier.
- R8: `boot_done` rises together with normal mode. It stays high until `rst` is asserted, and a later `rst` restarts the whole sequence from R1.
- R9: Activity on `ir_irq_n` and `dac_irq_n` before normal mode has no effect on the pins, which keep showing the boot pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| ir_irq_n | input | 1 | Infrared interface interrupt, active low, asynchronous |
| dac_irq_n | input | 1 | Audio DAC interrupt, active low, asynchronous |
| cpu_cold_rst_n | output | 1 | Cold reset to the CPU, active low |
| cpu_warm_rst_n | output | 1 | Warm reset to the CPU, active low |
| cpu_gnt_n | output | 1 | Bus grant pin: boot pattern bit, then parked high |
| cpu_irq_n | output | 4 | CPU interrupt pins: boot pattern, then routed interrupts |
| boot_done | output | 1 | High once normal mode has begun |

## Verification
Every sequencing result is due a fixed number of edges after `rst` is released: cold release after edge 64, warm release after edge 96, and the switch to normal mode after edge 100. The bench counts edges from the release and compares all outputs at the falling edge after each rising edge, against values computed from that count. Routed interrupts are due two edges after the input is sampled. The bench therefore keeps the inputs it drove at the last two falling edges and compares the pins with the older one. A second reset taken in the middle of normal mode checks that the sequence restarts from a count of zero.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    // Sequencer phases, in the order they occur after power-on reset.
    typedef enum logic [1:0] {
        PH_COLD   = 2'd0,
        PH_WARM   = 2'd1,
        PH_SETTLE = 2'd2,
        PH_RUN    = 2'd3
    } seq_phase_e;

    // Shared CPU-side pin group: bus grant plus the four interrupt lines.
    typedef struct packed {
        logic       gnt_n;
        logic [3:0] irq_n;
    } cpu_pins_t;

    // Synchronized external interrupt requests, both active low.
    typedef struct packed {
        logic dac_n;
        logic ir_n;
    } ext_irq_t;

    localparam int unsigned IRQ_LINES = 4;

    localparam cpu_pins_t PINS_PARKED = '{gnt_n: 1'b1, irq_n: 4'hF};

    // Maps the boot PROM width to the two-bit strap code.
    function automatic logic [1:0] prom_width_code(input int unsigned bits);
        case (bits)
            8:       return 2'b00;
            16:      return 2'b01;
            32:      return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    // Builds the configuration pattern that the CPU samples during reset.
    function automatic cpu_pins_t boot_pattern(input int unsigned bits,
                                               input bit          timer_en);
        cpu_pins_t p;
        p.gnt_n      = 1'b0;
        p.irq_n[3]   = 1'b1;
        p.irq_n[2]   = timer_en;
        p.irq_n[1:0] = prom_width_code(bits);
        return p;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/seq_phase_ctl.sv
module seq_phase_ctl
    import boot_seq_pkg::*;
#(
    parameter int unsigned COLD_CYC   = 64,
    parameter int unsigned WARM_CYC   = 32,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    output seq_phase_e phase
);

    localparam int unsigned MAX_CYC = max3(COLD_CYC, WARM_CYC, SETTLE_CYC);
    localparam int unsigned TW      = $clog2(MAX_CYC + 1);

    localparam logic [TW-1:0] COLD_LAST   = TW'(COLD_CYC - 1);
    localparam logic [TW-1:0] WARM_LAST   = TW'(WARM_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYC - 1);

    seq_phase_e    phase_q;
    seq_phase_e    phase_nxt;
    logic [TW-1:0] tmr_q;
    logic [TW-1:0] last_cnt;

    always_comb begin
        case (phase_q)
            PH_COLD:   begin last_cnt = COLD_LAST;   phase_nxt = PH_WARM;   end
            PH_WARM:   begin last_cnt = WARM_LAST;   phase_nxt = PH_SETTLE; end
            PH_SETTLE: begin last_cnt = SETTLE_LAST; phase_nxt = PH_RUN;    end
            default:   begin last_cnt = '0;          phase_nxt = PH_RUN;    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_COLD;
            tmr_q   <= '0;
        end else if (phase_q != PH_RUN) begin
            if (tmr_q == last_cnt) begin
                phase_q <= phase_nxt;
                tmr_q   <= '0;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din_n,
    output logic [WIDTH-1:0] dout_n
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= {chain_q[STAGES-2:0], din_n[b]};
        end

        assign dout_n[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/pin_router.sv
module pin_router
    import boot_seq_pkg::*;
#(
    parameter int unsigned BOOT_BITS = 16,
    parameter bit          TIMER_EN  = 1'b1
) (
    input  seq_phase_e phase,
    input  ext_irq_t   irq_s,
    output cpu_pins_t  pins,
    output logic       cold_n,
    output logic       warm_n,
    output logic       done
);

    localparam cpu_pins_t STRAPS = boot_pattern(BOOT_BITS, TIMER_EN);

    cpu_pins_t live;

    always_comb begin
        live          = PINS_PARKED;
        live.irq_n[0] = irq_s.ir_n;
        live.irq_n[1] = irq_s.dac_n;
    end

    assign done   = (phase == PH_RUN);
    assign cold_n = (phase != PH_COLD);
    assign warm_n = (phase == PH_SETTLE) || (phase == PH_RUN);
    assign pins   = done ? live : STRAPS;

endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
    import boot_seq_pkg::*;
#(
    parameter int unsigned COLD_CYC    = 64,
    parameter int unsigned WARM_CYC    = 32,
    parameter int unsigned SETTLE_CYC  = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BOOT_BITS   = 16,
    parameter bit          TIMER_EN    = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ir_irq_n,
    input  logic       dac_irq_n,
    output logic       cpu_cold_rst_n,
    output logic       cpu_warm_rst_n,
    output logic       cpu_gnt_n,
    output logic [3:0] cpu_irq_n,
    output logic       boot_done
);

    seq_phase_e phase;
    ext_irq_t   irq_raw;
    ext_irq_t   irq_s;
    cpu_pins_t  pins;

    assign irq_raw = '{dac_n: dac_irq_n, ir_n: ir_irq_n};

    seq_phase_ctl #(
        .COLD_CYC  (COLD_CYC),
        .WARM_CYC  (WARM_CYC),
        .SETTLE_CYC(SETTLE_CYC)
    ) i_phase (
        .clk  (clk),
        .rst  (rst),
        .phase(phase)
    );

    irq_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst   (rst),
        .din_n (irq_raw),
        .dout_n(irq_s)
    );

    pin_router #(
        .BOOT_BITS(BOOT_BITS),
        .TIMER_EN (TIMER_EN)
    ) i_route (
        .phase (phase),
        .irq_s (irq_s),
        .pins  (pins),
        .cold_n(cpu_cold_rst_n),
        .warm_n(cpu_warm_rst_n),
        .done  (boot_done)
    );

    assign cpu_gnt_n = pins.gnt_n;
    assign cpu_irq_n = pins.irq_n;

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
    parameter int unsigned COLD_CYC   = 64,
    parameter int unsigned WARM_CYC   = 32,
    parameter int unsigned SETTLE_CYC = 4,
    parameter int unsigned BOOT_BITS  = 16,
    parameter bit          TIMER_EN   = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       ir_irq_n,
    input logic       dac_irq_n,
    input logic       cpu_cold_rst_n,
    input logic       cpu_warm_rst_n,
    input logic       cpu_gnt_n,
    input logic [3:0] cpu_irq_n,
    input logic       boot_done
);

    localparam int unsigned WARM_AT  = COLD_CYC + WARM_CYC;
    localparam int unsigned RUN_AT   = WARM_AT + SETTLE_CYC;
    localparam int unsigned CW       = $clog2(RUN_AT + 1);
    localparam logic [1:0]  WCODE    = (BOOT_BITS == 8)  ? 2'b00 :
                                       (BOOT_BITS == 16) ? 2'b01 :
                                       (BOOT_BITS == 32) ? 2'b10 : 2'b11;

    // Edges seen since reset released, saturating once normal mode is due.
    logic [CW-1:0] since_rel;

    always_ff @(posedge clk) begin
        if (rst)                        since_rel <= '0;
        else if (since_rel != CW'(RUN_AT)) since_rel <= since_rel + 1'b1;
    end

    assert_cold_timing_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_cold_rst_n == (since_rel >= CW'(COLD_CYC)));

    assert_warm_timing_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_warm_rst_n == (since_rel >= CW'(WARM_AT)));

    assert_done_timing_R8: assert property (@(posedge clk) disable iff (rst)
        boot_done == (since_rel >= CW'(RUN_AT)));

    assert_strap_pattern_R4: assert property (@(posedge clk) disable iff (rst)
        !boot_done |-> (cpu_gnt_n == 1'b0 && cpu_irq_n[3] == 1'b1
                        && cpu_irq_n[1:0] == WCODE));

    assert_timer_strap_R5: assert property (@(posedge clk) disable iff (rst)
        !boot_done |-> (cpu_irq_n[2] == TIMER_EN));

    assert_parked_lines_R6: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> (cpu_gnt_n && cpu_irq_n[3:2] == 2'b11));

    assert_ir_latency_R7: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> (cpu_irq_n[0] == $past(ir_irq_n, 2)));

    assert_dac_latency_R7: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> (cpu_irq_n[1] == $past(dac_irq_n, 2)));

endmodule

bind boot_reset_seq boot_seq_chk #(
    .COLD_CYC  (COLD_CYC),
    .WARM_CYC  (WARM_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .BOOT_BITS (BOOT_BITS),
    .TIMER_EN  (TIMER_EN)
) i_boot_seq_chk (
    .clk           (clk),
    .rst           (rst),
    .ir_irq_n      (ir_irq_n),
    .dac_irq_n     (dac_irq_n),
    .cpu_cold_rst_n(cpu_cold_rst_n),
    .cpu_warm_rst_n(cpu_warm_rst_n),
    .cpu_gnt_n     (cpu_gnt_n),
    .cpu_irq_n     (cpu_irq_n),
    .boot_done     (boot_done)
);

// File: tb/test_boot_reset_seq.sv
module test_boot_reset_seq;

    localparam int CLK_PERIOD = 10;
    localparam int COLD_AT    = 64;
    localparam int WARM_AT    = 96;
    localparam int RUN_AT     = 100;
    localparam logic [3:0] STRAP_IRQ = 4'b1101;   // R4/R5 default pattern

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ir_irq_n = 1'b1;
    logic       dac_irq_n = 1'b1;
    logic       cpu_cold_rst_n;
    logic       cpu_warm_rst_n;
    logic       cpu_gnt_n;
    logic [3:0] cpu_irq_n;
    logic       boot_done;

    int n_chk  = 0;
    int n_fail = 0;

    boot_reset_seq i_boot_reset_seq (
        .clk           (clk),
        .rst           (rst),
        .ir_irq_n      (ir_irq_n),
        .dac_irq_n     (dac_irq_n),
        .cpu_cold_rst_n(cpu_cold_rst_n),
        .cpu_warm_rst_n(cpu_warm_rst_n),
        .cpu_gnt_n     (cpu_gnt_n),
        .cpu_irq_n     (cpu_irq_n),
        .boot_done     (boot_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int k,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s edge %0d: actual %b expected %b", req, k, act, exp);
        end
    endtask

    // Expected pins after k edges since release; irq = inputs two edges back.
    function automatic logic [4:0] exp_pins(input int k, input logic [1:0] irq);
        if (k < RUN_AT) return {1'b0, STRAP_IRQ};
        return {1'b1, 2'b11, irq[1], irq[0]};
    endfunction

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        ir_irq_n = 1'b1;
        dac_irq_n = 1'b1;
        repeat (cycles) @(posedge clk);
        @(negedge clk);
        // R1: forced values while reset is applied
        check("R1", 0, {5'b0, cpu_cold_rst_n, cpu_warm_rst_n, boot_done}, 8'b0);
        check("R1", 0, {3'b0, cpu_gnt_n, cpu_irq_n}, {3'b0, 1'b0, STRAP_IRQ});
        rst = 1'b0;
    endtask

    // Runs n edges after release; random inputs, plus a directed stretch.
    task automatic run_seq(input int n);
        logic [1:0] d1 = 2'b11;
        logic [1:0] d2 = 2'b11;
        logic [1:0] dn;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R2", k, {7'b0, cpu_cold_rst_n}, {7'b0, k >= COLD_AT});
            check("R3", k, {7'b0, cpu_warm_rst_n}, {7'b0, k >= WARM_AT});
            check("R8", k, {7'b0, boot_done}, {7'b0, k >= RUN_AT});
            if (k < RUN_AT)
                check("R9", k, {3'b0, cpu_gnt_n, cpu_irq_n}, {3'b0, exp_pins(k, d2)});
            else if (k == RUN_AT)
                check("R6", k, {3'b0, cpu_gnt_n, cpu_irq_n}, {3'b0, exp_pins(k, d2)});
            else
                check("R7", k, {3'b0, cpu_gnt_n, cpu_irq_n}, {3'b0, exp_pins(k, d2)});
            if (k >= 120 && k < 126)      dn = 2'b00;      // both asserted
            else if (k >= 126 && k < 130) dn = 2'b10;      // IR only
            else                          dn = 2'($urandom);
            ir_irq_n  = dn[0];
            dac_irq_n = dn[1];
            d2 = d1;
            d1 = dn;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0B07));
        do_reset(4);
        run_seq(160);
        // R8: done stays high through normal mode, reset restarts from R1
        check("R8", 160, {7'b0, boot_done}, 8'd1);
        do_reset(3);
        run_seq(110);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule